// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit adds, subtracts or negates one byte of packed decimal data per clock cycle. Each byte holds two decimal digits, four bits each, with the tens digit in the upper nibble. An incoming extend bit goes into every operation. The unit returns the decimal result, a carry or borrow flag, and a matching extend flag. It also returns a zero flag that can only be cleared, never set, so a whole string can be tested for zero.

The result and flags are registered and come with a one-cycle valid pulse. A string of decimal bytes is fed least significant byte first, one byte per cycle. For each byte, the caller passes the extend and zero flags produced by the previous byte back in as `x_in` and `z_in`. To start a string, clear the extend flag and set the zero flag. Bytes that are not valid decimal still give a defined output, and no error is reported.

Top module: `bcd_byte_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operation, `out_valid`, `result`, `c_out`, `x_out` and `z_out` are all 0.
- R2: With `op` = 2'b00 (add), `result` is (src + dst + x_in) mod 100 in packed decimal (tens digit in bits 7:4, units in bits 3:0). `c_out` is 1 exactly when the decimal sum reaches 100.
- R3: With `op` = 2'b01 (subtract), `result` is (dst - src - x_in) mod 100 in packed decimal. `c_out` is 1 exactly when that difference is negative.
- R4: With `op` = 2'b10 (negate), `result` is (0 - dst - x_in) mod 100, and `c_out` is 1 exactly when the difference is negative. `src` has no effect on the output.
- R5: `x_out` always equals `c_out` after an accepted operation.
- R6: `z_out` is 0 when the new `result` is nonzero. When `result` is zero, `z_out` equals the `z_in` given with the operation.
- R7: An operation is accepted when `in_valid` is 1 and `op` is not 2'b11. Its outputs appear on the next cycle with `out_valid` high for exactly that one cycle. When nothing is accepted, `result` and the flags keep their values.
- R8: `op` = 2'b11 is reserved. It is not accepted: `out_valid` stays 0 on the next cycle and `result` and the flags do not change.
- R9: Bytes of a multi-byte string can be accepted on consecutive cycles, each with `x_in`/`z_in` taken from the previous byte's `x_out`/`z_out`. The chain then yields the decimal sum, difference or negation of the whole string.
- R10: For operands that are not valid decimal, `result` and all flags are still known 0/1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 2 | 00 add, 01 subtract, 10 negate, 11 reserved |
| src | input | 8 | Source packed decimal byte |
| dst | input | 8 | Destination packed decimal byte |
| x_in | input | 1 | Incoming extend bit |
| z_in | input | 1 | Incoming zero flag |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| result | output | 8 | Packed decimal result |
| c_out | output | 1 | Decimal carry or borrow out of tens digit |
| x_out | output | 1 | Extend flag, copy of the carry |
| z_out | output | 1 | Sticky zero flag |

## Verification
Within a single cycle, the unit delivers the registered result of one string byte and accepts the next byte, whose extend and zero inputs are taken from that same result. The bench drives four-byte add, subtract and negate strings back to back, one byte per cycle, and feeds `x_out`/`z_out` straight back into `x_in`/`z_in`. Every output byte is checked against a decimal model that chains its own carry and zero flags independently of the design. Strings that are entirely zero and strings that borrow through every byte are included, so a carry or zero flag taken from the wrong cycle shows up as a wrong digit or flag.

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] op,
  input  logic [7:0] src,
  input  logic [7:0] dst,
  input  logic       x_in,
  input  logic       z_in,
  output logic       out_valid,
  output logic [7:0] result,
  output logic       c_out,
  output logic       x_out,
  output logic       z_out
);
  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_NEG = 2'd2;
  localparam logic [1:0] OP_RSV = 2'd3;

  wire       take   = in_valid && (op != OP_RSV);
  wire       is_add = (op == OP_ADD);
  wire [7:0] a      = (op == OP_NEG) ? 8'h00 : dst;
  wire [7:0] b      = (op == OP_NEG) ? dst : src;

  logic [4:0] lo_t, hi_t;
  logic       lo_k, hi_k;
  logic [3:0] lo_v, hi_v;

  always_comb begin
    if (is_add) begin
      lo_t = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, x_in};
      lo_k = lo_t > 5'd9;
      lo_v = lo_t[3:0] + (lo_k ? 4'd6 : 4'd0);
      hi_t = {1'b0, a[7:4]} + {1'b0, b[7:4]} + {4'b0, lo_k};
      hi_k = hi_t > 5'd9;
      hi_v = hi_t[3:0] + (hi_k ? 4'd6 : 4'd0);
    end else begin
      lo_t = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, x_in};
      lo_k = lo_t[4];
      lo_v = lo_t[3:0] - (lo_k ? 4'd6 : 4'd0);
      hi_t = {1'b0, a[7:4]} - {1'b0, b[7:4]} - {4'b0, lo_k};
      hi_k = hi_t[4];
      hi_v = hi_t[3:0] - (hi_k ? 4'd6 : 4'd0);
    end
  end

  wire [7:0] sum_v = {hi_v, lo_v};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 8'h00;
      c_out     <= 1'b0;
      x_out     <= 1'b0;
      z_out     <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        result <= sum_v;
        c_out  <= hi_k;
        x_out  <= hi_k;
        z_out  <= z_in && (sum_v == 8'h00);
      end
    end
  end

  // R5
  cx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c_out == x_out));

  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!out_valid && $stable(result) && $stable(c_out) && $stable(z_out)));

  // R6
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !z_in) |=> !z_out);

  // R6
  nonzero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && result != 8'h00) |-> !z_out);
endmodule

// File: tb/sim_bcd_byte_alu.sv
module sim_bcd_byte_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] src = 8'h00, dst = 8'h00;
  logic       x_in = 1'b0, z_in = 1'b0;
  logic       out_valid, c_out, x_out, z_out;
  logic [7:0] result;

  bcd_byte_alu u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src(src), .dst(dst), .x_in(x_in), .z_in(z_in), .out_valid(out_valid),
    .result(result), .c_out(c_out), .x_out(x_out), .z_out(z_out));

  always #5 clk = ~clk;

  typedef struct {
    string      tag;
    logic [7:0] r;
    logic       c;
    logic       z;
    logic       known_only;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic m_x, m_z;

  task automatic check(input string tag, input logic ok, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dec(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // Decimal model: returns {carry, zero, result}
  function automatic logic [9:0] model(input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                                       input logic x, input logic z);
    int v;
    logic c;
    logic [7:0] r;
    if (o == 2'd0) begin
      v = dec(s) + dec(d) + int'(x);
      c = (v >= 100);
      v = v % 100;
    end else begin
      v = (o == 2'd1) ? dec(d) - dec(s) - int'(x) : 0 - dec(d) - int'(x);
      c = (v < 0);
      v = (v + 100) % 100;
    end
    r = {4'(v / 10), 4'(v % 10)};
    return {c, z && (r == 8'h00), r};
  endfunction

  task automatic issue(input string tag, input logic [1:0] o, input logic [7:0] s, input logic [7:0] d,
                       input logic x, input logic z, input logic unk);
    exp_t e;
    logic [9:0] m;
    @(negedge clk);
    in_valid = 1'b1; op = o; src = s; dst = d; x_in = x; z_in = z;
    m = model(o, s, d, x, z);
    e.tag = tag; e.r = m[7:0]; e.c = m[9]; e.z = m[8]; e.known_only = unk;
    if (o != 2'd3) q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R9: chained string, LSB first, flags fed back from the ports
  task automatic chain(input string tag, input logic [1:0] o, input logic [31:0] s, input logic [31:0] d);
    logic [9:0] m;
    exp_t e;
    m_x = 1'b0; m_z = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; op = o; src = s[8*i +: 8]; dst = d[8*i +: 8];
      x_in = (i == 0) ? 1'b0 : x_out;
      z_in = (i == 0) ? 1'b1 : z_out;
      m = model(o, s[8*i +: 8], d[8*i +: 8], m_x, m_z);
      m_x = m[9]; m_z = m[8];
      e.tag = tag; e.r = m[7:0]; e.c = m[9]; e.z = m[8]; e.known_only = 1'b0;
      q.push_back(e);
    end
    idle();
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check("R7 unexpected out_valid", 1'b0, 16'(out_valid), 16'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.known_only) begin
          check("R10 known outputs", !$isunknown({result, c_out, x_out, z_out}),
                {5'b0, result, c_out, x_out, z_out}, 16'h0);
        end else begin
          check(e.tag, (result == e.r) && (c_out == e.c), {7'b0, c_out, result}, {7'b0, e.c, e.r});
          check("R5 x equals c", x_out == c_out, 16'(x_out), 16'(c_out));
          check("R6 sticky zero", z_out == e.z, 16'(z_out), 16'(e.z));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset state", {out_valid, result, c_out, x_out, z_out} == 12'h0,
          {4'b0, out_valid, result, c_out, x_out, z_out}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {out_valid, result, c_out, x_out, z_out} == 12'h0,
          {4'b0, out_valid, result, c_out, x_out, z_out}, 16'h0);

    // R2 add
    issue("R2 add basic", 2'd0, 8'h23, 8'h45, 1'b0, 1'b1, 1'b0);
    issue("R2 add digit carry", 2'd0, 8'h08, 8'h08, 1'b0, 1'b1, 1'b0);
    issue("R2 add max with x", 2'd0, 8'h99, 8'h99, 1'b1, 1'b1, 1'b0);
    issue("R2 add to hundred", 2'd0, 8'h50, 8'h50, 1'b0, 1'b1, 1'b0);
    // R3 subtract
    issue("R3 sub basic", 2'd1, 8'h17, 8'h42, 1'b0, 1'b0, 1'b0);
    issue("R3 sub borrow", 2'd1, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0);
    issue("R3 sub with x", 2'd1, 8'h33, 8'h34, 1'b1, 1'b1, 1'b0);
    // R4 negate, src has no effect
    issue("R4 neg zero", 2'd0 + 2'd2, 8'h77, 8'h00, 1'b0, 1'b1, 1'b0);
    issue("R4 neg zero with x", 2'd2, 8'h55, 8'h00, 1'b1, 1'b1, 1'b0);
    issue("R4 neg value", 2'd2, 8'h99, 8'h38, 1'b0, 1'b1, 1'b0);
    // R6 nonzero clears, zero keeps z_in low
    issue("R6 zero result z_in low", 2'd1, 8'h12, 8'h12, 1'b0, 1'b0, 1'b0);
    // R10 invalid digits
    issue("R10", 2'd0, 8'hFA, 8'h9C, 1'b1, 1'b1, 1'b1);
    issue("R10", 2'd1, 8'hAF, 8'h3B, 1'b0, 1'b1, 1'b1);
    idle();
    @(negedge clk);

    // R7 single pulse then hold
    issue("R7 single op", 2'd0, 8'h11, 8'h22, 1'b0, 1'b1, 1'b0);
    idle();
    check("R7 pulse high", out_valid == 1'b1, 16'(out_valid), 16'h1);
    held = result;
    @(negedge clk);
    check("R7 pulse ends", out_valid == 1'b0, 16'(out_valid), 16'h0);
    check("R7 result held", result == held, 16'(result), 16'(held));

    // R8 reserved op is not accepted
    issue("R8", 2'd3, 8'h44, 8'h55, 1'b1, 1'b0, 1'b0);
    idle();
    check("R8 no valid", out_valid == 1'b0, 16'(out_valid), 16'h0);
    check("R8 result unchanged", {result, c_out, z_out} == {held, 1'b0, 1'b0},
          {6'b0, result, c_out, z_out}, {6'b0, held, 2'b00});

    // R9 strings back to back
    chain("R9 add string", 2'd0, 32'h0000_0001, 32'h0099_9999);
    chain("R9 sub string", 2'd1, 32'h0000_0001, 32'h0100_0000);
    chain("R9 neg string", 2'd2, 32'h0000_0000, 32'h0000_0001);
    chain("R9 zero string", 2'd1, 32'h1234_5678, 32'h1234_5678);
    chain("R9 neg all zero", 2'd2, 32'h0000_0000, 32'h0000_0000);
    repeat (3) @(negedge clk);
    check("R7 all results seen", q.size() == 0, 16'(q.size()), 16'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule